// File: doc/BRIEF.md
# PCI Target Parity Error Reporter

This block watches the shared address/data bus of a PCI target and checks the parity the initiator supplies. For every address phase, and for every data phase in which the device is the target and receives data, it forms the even parity of the 32 address/data lines and the 4 command/byte-enable lines. It compares that parity with the PAR line one clock later. Mismatches are recorded in two status bits and reported on the bus through the data-parity-error line (PERR#) and the system-error line (SERR#). Both lines are gated by the parity-response and system-error enable bits of the command word.

The surrounding target logic tells the block which cycles carry an address phase or a checked data phase. It passes in the current command register value and forwards configuration writes aimed at the status register. A data-phase error never ends the transaction early. The block has no output that could stop or abort the cycle, so recovery is left to the initiator. An address-phase error is reported through SERR# only when both enables are set. In every other case the error is only recorded.

Top module: `pci_parity_reporter`

## Requirements
- R1: For a marked phase in cycle N, with AD and C/BE# sampled in N and PAR sampled in N+1, an error is flagged when the XOR of all 32 AD bits, all 4 C/BE# bits and PAR is 1. Cycles with neither phase input high are never checked, whatever PAR holds.
- R2: A data-phase parity error sets status bit 15 (detected parity error), visible from cycle N+2. This happens whatever the command bits hold.
- R3: A data-phase error while command bit 6 (parity error response) is 1 drives perr_n_o low with perr_oe_o high in cycle N+2. perr_n_o is then driven high, with perr_oe_o still high, in cycle N+3, and perr_oe_o returns to 0 in cycle N+4. With command bit 6 at 0, perr_oe_o stays 0.
- R4: A data-phase error never asserts serr_n_o and never sets status bit 14. The block offers no path by which the error ends the transfer.
- R5: An address-phase error while command bit 6 or command bit 8 (system error enable) is 0 sets status bit 15 only. serr_n_o stays 1 and status bit 14 stays 0.
- R6: An address-phase error while command bits 6 and 8 are both 1 sets status bits 14 (signalled system error) and 15. It drives serr_n_o low for exactly one clock, in cycle N+2.
- R7: An address-phase error never drives PERR# (perr_oe_o stays 0).
- R8: A status write with a 1 in bit 14 or bit 15 clears that bit on the next clock. A 0 leaves it unchanged. All other status bits read 0. A set and a clear of the same bit in the same clock leave the bit set.
- R9: After reset, status_o is 0, perr_oe_o is 0, perr_n_o is 1 and serr_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 32 | Address/data lines as sampled |
| cbe_n_i | input | 4 | Command/byte-enable lines as sampled |
| par_i | input | 1 | Parity line, valid one clock after its phase |
| addr_phase_i | input | 1 | High in an address phase cycle |
| data_phase_i | input | 1 | High in a completed data phase in which this target receives data |
| cmd_i | input | 16 | Command register value (bit 6 parity response, bit 8 system error enable) |
| stat_wr_i | input | 1 | Write strobe for the status register |
| stat_wdata_i | input | 16 | Status write data, ones clear bits 14 and 15 |
| status_o | output | 16 | Status register view (bits 14 and 15 used) |
| perr_n_o | output | 1 | PERR# drive value |
| perr_oe_o | output | 1 | PERR# output enable |
| serr_n_o | output | 1 | SERR# drive value, low while asserted |

## Verification
The assertions check on every cycle that SERR# is never held low for two clocks in a row, and that any low SERR# or PERR# comes with the matching status bit. They also check that PERR# is always driven high before it is released, and that one flagged error never requests both lines at once. Only the bench scenarios can show that the exact parity rule is used and that the reporting lands two clocks after the phase. The bench also shows the gating of each enable combination, that idle cycles are ignored, and the write-one-to-clear rule, including a set colliding with a clear.

// File: rtl/pci_par_pkg.sv
// Package: shared constants and types for the PCI parity error reporter.
// Assumes a 16-bit command and status register layout as used on the bus.
package pci_par_pkg;

    localparam int CFG_W        = 16;
    localparam int PERR_RESP_B  = 6;   // command: parity error response
    localparam int SERR_EN_B    = 8;   // command: system error enable
    localparam int SSE_B        = 14;  // status: signalled system error
    localparam int DPE_B        = 15;  // status: detected parity error

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e kind;
        logic   parity;
    } par_stage_t;

endpackage

// File: rtl/pci_par_calc.sv
// Module: first pipeline stage. Captures the kind of the current phase
// and the even parity of AD and C/BE# so it can be compared with PAR,
// which arrives one clock later. Assumes the two phase inputs are never
// high together.
module pci_par_calc
    import pci_par_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    input  logic             addr_phase_i,
    input  logic             data_phase_i,
    output par_stage_t       stage_o
);

    par_stage_t stage_q;

    // Register phase kind and parity of the sampled bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q.kind   <= PH_IDLE;
            stage_q.parity <= 1'b0;
        end else begin
            if (addr_phase_i)      stage_q.kind <= PH_ADDR;
            else if (data_phase_i) stage_q.kind <= PH_DATA;
            else                   stage_q.kind <= PH_IDLE;
            stage_q.parity <= ^{ad_i, cbe_n_i};
        end
    end

    assign stage_o = stage_q;

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_phase_i && data_phase_i)); // R1

endmodule

// File: rtl/pci_par_compare.sv
// Module: second stage, combinational. Compares the stored parity with
// PAR and decides which report each error asks for, based on the
// command enables present in the PAR cycle.
module pci_par_compare
    import pci_par_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  par_stage_t       stage_i,
    input  logic             par_i,
    input  logic [CFG_W-1:0] cmd_i,
    output logic             err_any_o,
    output logic             perr_fire_o,
    output logic             serr_fire_o
);

    logic mismatch;
    logic err_addr;
    logic err_data;

    // Classify a parity mismatch by the phase kind it belongs to.
    always_comb begin
        mismatch    = stage_i.parity ^ par_i;
        err_addr    = mismatch && (stage_i.kind == PH_ADDR);
        err_data    = mismatch && (stage_i.kind == PH_DATA);
        err_any_o   = err_addr || err_data;
        perr_fire_o = err_data && cmd_i[PERR_RESP_B];
        serr_fire_o = err_addr && cmd_i[PERR_RESP_B] && cmd_i[SERR_EN_B];
    end

    AST_ONE_REPORT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(perr_fire_o && serr_fire_o)); // R7

endmodule

// File: rtl/pci_par_status.sv
// Module: holds the two error status bits with write-one-to-clear
// behaviour. A new error wins over a clear in the same clock.
module pci_par_status
    import pci_par_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_any_i,
    input  logic             serr_fire_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] status_o
);

    logic dpe_q;
    logic sse_q;

    // Update the detected parity error bit.
    always_ff @(posedge clk) begin
        if (!rst_n) dpe_q <= 1'b0;
        else        dpe_q <= err_any_i || (dpe_q && !(wr_i && wdata_i[DPE_B]));
    end

    // Update the signalled system error bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sse_q <= 1'b0;
        else        sse_q <= serr_fire_i || (sse_q && !(wr_i && wdata_i[SSE_B]));
    end

    // Place the bits at their register positions.
    always_comb begin
        status_o        = '0;
        status_o[DPE_B] = dpe_q;
        status_o[SSE_B] = sse_q;
    end

    AST_DPE_SET_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_any_i |=> status_o[DPE_B]); // R2
    AST_SSE_NEEDS_DPE: assert property (@(posedge clk) disable iff (!rst_n)
        serr_fire_i |=> (status_o[SSE_B] && status_o[DPE_B])); // R6

endmodule

// File: rtl/pci_perr_drive.sv
// Module: produces the PERR# and SERR# pin values. PERR# is pulled low
// for one clock, driven high for one clock, then released. SERR# is a
// one-clock low pulse. Assumes address phases are at least two clocks apart.
module pci_perr_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic perr_fire_i,
    input  logic serr_fire_i,
    output logic perr_n_o,
    output logic perr_oe_o,
    output logic serr_n_o
);

    logic perr_low_q;
    logic perr_high_q;
    logic serr_q;

    // Sequence PERR#: low clock, then high clock, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_low_q  <= 1'b0;
            perr_high_q <= 1'b0;
        end else begin
            perr_low_q  <= perr_fire_i;
            perr_high_q <= perr_low_q;
        end
    end

    // Pulse SERR# for the clock after an address error is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_q <= 1'b0;
        else        serr_q <= serr_fire_i;
    end

    assign perr_oe_o = perr_low_q || perr_high_q;
    assign perr_n_o  = !perr_low_q;
    assign serr_n_o  = !serr_q;

    AST_PERR_HIGH_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_oe_o) |-> $past(perr_n_o)); // R3
    AST_SERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n_o |=> serr_n_o); // R6

endmodule

// File: rtl/pci_parity_reporter.sv
// Module: top of the PCI target parity error reporter. Chains the parity
// capture stage, the comparator, the status bits and the pin driver.
// Assumes the caller marks address phases and checked target data phases.
module pci_parity_reporter
    import pci_par_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    input  logic             par_i,
    input  logic             addr_phase_i,
    input  logic             data_phase_i,
    input  logic [CFG_W-1:0] cmd_i,
    input  logic             stat_wr_i,
    input  logic [CFG_W-1:0] stat_wdata_i,
    output logic [CFG_W-1:0] status_o,
    output logic             perr_n_o,
    output logic             perr_oe_o,
    output logic             serr_n_o
);

    par_stage_t stage;
    logic       err_any;
    logic       perr_fire;
    logic       serr_fire;

    pci_par_calc #(.AD_W(AD_W), .CBE_W(CBE_W)) calc_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
        .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i),
        .stage_o(stage)
    );

    pci_par_compare cmp_i (
        .clk(clk), .rst_n(rst_n), .stage_i(stage), .par_i(par_i),
        .cmd_i(cmd_i), .err_any_o(err_any), .perr_fire_o(perr_fire),
        .serr_fire_o(serr_fire)
    );

    pci_par_status stat_i (
        .clk(clk), .rst_n(rst_n), .err_any_i(err_any),
        .serr_fire_i(serr_fire), .wr_i(stat_wr_i),
        .wdata_i(stat_wdata_i), .status_o(status_o)
    );

    pci_perr_drive drv_i (
        .clk(clk), .rst_n(rst_n), .perr_fire_i(perr_fire),
        .serr_fire_i(serr_fire), .perr_n_o(perr_n_o),
        .perr_oe_o(perr_oe_o), .serr_n_o(serr_n_o)
    );

    AST_SERR_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n_o |-> status_o[SSE_B]); // R6
    AST_PERR_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe_o && !perr_n_o) |-> status_o[DPE_B]); // R2

endmodule

// File: tb/pci_parity_reporter_tb_top.sv
module pci_parity_reporter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_n_i = '0;
    logic        par_i = 1'b0;
    logic        addr_phase_i = 1'b0;
    logic        data_phase_i = 1'b0;
    logic [15:0] cmd_i = '0;
    logic        stat_wr_i = 1'b0;
    logic [15:0] stat_wdata_i = '0;
    logic [15:0] status_o;
    logic        perr_n_o, perr_oe_o, serr_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pci_parity_reporter dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
        .par_i(par_i), .addr_phase_i(addr_phase_i),
        .data_phase_i(data_phase_i), .cmd_i(cmd_i),
        .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
        .status_o(status_o), .perr_n_o(perr_n_o),
        .perr_oe_o(perr_oe_o), .serr_n_o(serr_n_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cmd(input bit perr_en, input bit serr_en);
        cmd_i = '0;
        cmd_i[6] = perr_en;
        cmd_i[8] = serr_en;
    endtask

    task automatic clear_status();
        @(negedge clk);
        stat_wr_i = 1'b1; stat_wdata_i = 16'hC000;
        @(negedge clk);
        stat_wr_i = 1'b0; stat_wdata_i = '0;
    endtask

    // One phase in cycle N, PAR in N+1; returns at the sample point of N+2.
    task automatic run_phase(input bit is_addr, input logic [31:0] ad,
                             input logic [3:0] cbe, input bit bad, input bit clr);
        @(negedge clk);
        ad_i = ad; cbe_n_i = cbe;
        addr_phase_i = is_addr; data_phase_i = !is_addr;
        @(negedge clk);
        addr_phase_i = 1'b0; data_phase_i = 1'b0;
        ad_i = ~ad;
        par_i = (^{ad, cbe}) ^ bad;
        if (clr) begin stat_wr_i = 1'b1; stat_wdata_i = 16'hFFFF; end
        @(negedge clk);
        stat_wr_i = 1'b0; stat_wdata_i = '0;
        par_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 status", status_o, 16'h0000);
        check("R9 perr_oe", perr_oe_o, 0);
        check("R9 perr_n", perr_n_o, 1);
        check("R9 serr_n", serr_n_o, 1);
    endtask

    task automatic t_clean();
        set_cmd(1, 1);
        run_phase(1, 32'h0000_0000, 4'h0, 0, 0);
        check("R1 clean addr zeros", {status_o, 13'b0, perr_oe_o, serr_n_o, 1'b0}, 32'h0000_0002);
        run_phase(0, 32'hFFFF_FFFF, 4'hF, 0, 0);
        check("R1 clean data ones", {status_o, 13'b0, perr_oe_o, serr_n_o, 1'b0}, 32'h0000_0002);
        run_phase(0, 32'h8000_0001, 4'h1, 0, 0);
        check("R1 clean data odd", {status_o, 13'b0, perr_oe_o, serr_n_o, 1'b0}, 32'h0000_0002);
        run_phase(1, 32'h1234_5678, 4'h6, 0, 0);
        check("R1 clean addr mix", {status_o, 13'b0, perr_oe_o, serr_n_o, 1'b0}, 32'h0000_0002);
        // idle cycles with wrong PAR are not checked
        @(negedge clk); ad_i = 32'h0000_0001; cbe_n_i = 4'h0;
        @(negedge clk); par_i = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 idle ignored status", status_o, 16'h0000);
        check("R1 idle ignored perr_oe", perr_oe_o, 0);
    endtask

    task automatic t_data_err(input bit perr_en, input bit serr_en);
        string tg;
        clear_status();
        set_cmd(perr_en, serr_en);
        tg = $sformatf("en%0d%0d", perr_en, serr_en);
        run_phase(0, 32'hA5A5_0F0F, 4'h3, 1, 0);
        check({"R2 dpe ", tg}, status_o, 16'h8000);
        check({"R4 no serr ", tg}, serr_n_o, 1);
        check({"R3 perr_oe N+2 ", tg}, perr_oe_o, perr_en);
        check({"R3 perr_n N+2 ", tg}, perr_n_o, !perr_en);
        @(negedge clk);
        check({"R3 perr_oe N+3 ", tg}, perr_oe_o, perr_en);
        check({"R3 perr_n N+3 ", tg}, perr_n_o, 1);
        check({"R4 serr N+3 ", tg}, serr_n_o, 1);
        @(negedge clk);
        check({"R3 release N+4 ", tg}, perr_oe_o, 0);
        check({"R4 no sse ", tg}, status_o, 16'h8000);
    endtask

    task automatic t_addr_err(input bit perr_en, input bit serr_en);
        string tg;
        bit both;
        both = perr_en && serr_en;
        clear_status();
        set_cmd(perr_en, serr_en);
        tg = $sformatf("en%0d%0d", perr_en, serr_en);
        run_phase(1, 32'h0000_1000, 4'h7, 1, 0);
        if (both) begin
            check({"R6 status ", tg}, status_o, 16'hC000);
            check({"R6 serr low N+2 ", tg}, serr_n_o, 0);
        end else begin
            check({"R5 status ", tg}, status_o, 16'h8000);
            check({"R5 serr high ", tg}, serr_n_o, 1);
        end
        check({"R7 no perr ", tg}, perr_oe_o, 0);
        @(negedge clk);
        check({"R6 serr one clock ", tg}, serr_n_o, 1);
        check({"R7 no perr N+3 ", tg}, perr_oe_o, 0);
    endtask

    task automatic t_w1c();
        clear_status();
        set_cmd(1, 1);
        run_phase(1, 32'hDEAD_BEEF, 4'h2, 1, 0);
        check("R8 both set", status_o, 16'hC000);
        @(negedge clk); stat_wr_i = 1'b1; stat_wdata_i = 16'h3FFF;
        @(negedge clk); stat_wr_i = 1'b0;
        check("R8 zero write keeps", status_o, 16'hC000);
        @(negedge clk); stat_wr_i = 1'b1; stat_wdata_i = 16'h8000;
        @(negedge clk); stat_wr_i = 1'b0;
        check("R8 clear bit15", status_o, 16'h4000);
        @(negedge clk); stat_wr_i = 1'b1; stat_wdata_i = 16'h4000;
        @(negedge clk); stat_wr_i = 1'b0;
        check("R8 clear bit14", status_o, 16'h0000);
        // set and clear collide: set wins
        run_phase(1, 32'h0F0F_0F0F, 4'h9, 1, 1);
        check("R8 set beats clear", status_o, 16'hC000);
        clear_status();
        check("R8 cleared after collide", status_o, 16'h0000);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_data_err(1, 0);
        t_data_err(0, 1);
        t_data_err(1, 1);
        t_addr_err(0, 0);
        t_addr_err(1, 0);
        t_addr_err(0, 1);
        t_addr_err(1, 1);
        t_w1c();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule